// File: doc/BRIEF.md
# Translation Lookaside Buffer with Page Protection

This block is a small, fully associative cache of page translations. Each slot records a 12-bit virtual page number, the 12-bit physical page number it maps to, and four permission flags: read, write, execute and user-accessible. A lookup presents a 24-bit virtual address, an access kind and the current privilege level. One cycle later the block reports one of three results. A hit carries the translated physical address. A miss tells an external walker to fetch the mapping. A protection fault means the page is cached but the access is not allowed.

The walker installs a mapping through a refill port. Installing entries counts as a privileged write, so the block refuses any refill request that does not come with supervisor privilege and flags the refusal. If the page is already cached, the refill overwrites that slot in place. Otherwise it takes the slot named by a round-robin pointer. A flush input invalidates every slot in one cycle.

Top module: `tlb_prot`

## Requirements
- R1: After reset, `rsp_valid` and `rf_reject` are low and every slot is invalid, so the first lookup reports a miss.
- R2: `rsp_valid` is high exactly one cycle after a cycle with `lk_req` high. When `rsp_valid` is high, exactly one of `rsp_hit`, `rsp_miss`, `rsp_fault` is high. When `rsp_valid` is low, all three are low.
- R3: A lookup whose page number (bits 23:12 of `lk_vaddr`) matches no valid slot reports `rsp_miss` and a zero `rsp_paddr`.
- R4: A permitted lookup that matches a slot reports `rsp_hit`. `rsp_paddr` is then the slot's physical page number in bits 23:12 and the request's bits 11:0, unchanged.
- R5: On a match, the access kind is checked against the slot's flags. `lk_acc` 0 is read and needs flag bit 0. `lk_acc` 1 is write and needs bit 1. `lk_acc` 2 is execute and needs bit 2. `lk_acc` 3 is never allowed. If the needed flag is clear, `rsp_fault` is high and `rsp_hit` is low.
- R6: Flag bit 3 marks a user-accessible page. A matching lookup with `lk_sup` low on a page whose bit 3 is clear faults. Supervisor lookups ignore bit 3.
- R7: A refill request with `rf_sup` low leaves the table unchanged. It raises `rf_reject` for one cycle, in the cycle after the request.
- R8: A supervisor refill whose page number is already cached overwrites that slot in place and does not advance the round-robin pointer.
- R9: A supervisor refill of an uncached page writes the slot under the round-robin pointer. The pointer then advances, wrapping after the last slot, so the oldest allocation is evicted first.
- R10: `fl_req` invalidates every slot in one cycle. A lookup in the same cycle as the flush reports a miss.
- R11: A lookup in the same cycle as a refill sees the table as it was before that refill.
- R12: When `fl_req` and a refill arrive in the same cycle, the flush wins and the refill is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 24 | Virtual address to translate |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| lk_sup | input | 1 | Lookup issued at supervisor privilege |
| fl_req | input | 1 | Invalidate all slots |
| rf_req | input | 1 | Refill request |
| rf_vpn | input | 12 | Refill virtual page number |
| rf_ppn | input | 12 | Refill physical page number |
| rf_perm | input | 4 | Refill flags: bit0 read, bit1 write, bit2 execute, bit3 user |
| rf_sup | input | 1 | Refill issued at supervisor privilege |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Permitted translation found |
| rsp_miss | output | 1 | No valid slot for the page |
| rsp_fault | output | 1 | Slot found but access forbidden |
| rsp_paddr | output | 24 | Physical address on a hit, else zero |
| rf_reject | output | 1 | Previous refill refused for lack of privilege |

## Verification
Three functions can land in the same cycle: a lookup, a refill and a flush. The bench drives a lookup together with a refill of the same page, then a lookup together with a flush and a refill. Each combined cycle is judged twice: first by the response to that same-cycle lookup, which must show the old table or a miss, and then by follow-up lookups, which show whether the refill was kept or dropped. A separate sequence fills every slot, overwrites one cached page, and then allocates two more pages. This exposes whether an in-place overwrite disturbed the round-robin order.

// File: rtl/tlb_prot_pkg.sv
package tlb_prot_pkg;
    localparam int unsigned OFF_W = 12;
    localparam int unsigned VPN_W = 12;
    localparam int unsigned PPN_W = 12;
    localparam int unsigned VA_W  = VPN_W + OFF_W;
    localparam int unsigned PA_W  = PPN_W + OFF_W;

    typedef enum logic [1:0] {
        ACC_RD  = 2'd0,
        ACC_WR  = 2'd1,
        ACC_EX  = 2'd2,
        ACC_BAD = 2'd3
    } acc_e;

    typedef struct packed {
        logic u;
        logic x;
        logic w;
        logic r;
    } perm_t;

    typedef struct packed {
        logic             valid;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
        perm_t            perm;
    } entry_t;
endpackage

// File: rtl/tlb_prot_cam.sv
module tlb_prot_cam
    import tlb_prot_pkg::*;
#(
    parameter int unsigned N_ENT = 8,
    localparam int unsigned IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  entry_t [N_ENT-1:0] ents,
    input  logic [VPN_W-1:0]   vpn,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);
    logic [N_ENT-1:0] match;

    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        assign match[g] = ents[g].valid && (ents[g].vpn == vpn);
    end

    always_comb begin
        any = |match;
        idx = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (match[i]) idx = idx | IDX_W'(i);
        end
    end
endmodule

// File: rtl/tlb_prot_perm.sv
module tlb_prot_perm
    import tlb_prot_pkg::*;
(
    input  perm_t perm,
    input  acc_e  acc,
    input  logic  sup,
    output logic  allow
);
    logic kind_ok;

    always_comb begin
        case (acc)
            ACC_RD:  kind_ok = perm.r;
            ACC_WR:  kind_ok = perm.w;
            ACC_EX:  kind_ok = perm.x;
            default: kind_ok = 1'b0;
        endcase
        allow = kind_ok && (sup || perm.u);
    end
endmodule

// File: rtl/tlb_prot_rr.sv
module tlb_prot_rr #(
    parameter int unsigned N_ENT = 8,
    localparam int unsigned IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic [IDX_W-1:0] ptr,
    input  logic             adv,
    output logic [IDX_W-1:0] ptr_nx
);
    always_comb begin
        if (!adv)                          ptr_nx = ptr;
        else if (ptr == IDX_W'(N_ENT - 1)) ptr_nx = '0;
        else                               ptr_nx = ptr + IDX_W'(1);
    end
endmodule

// File: rtl/tlb_prot.sv
module tlb_prot
    import tlb_prot_pkg::*;
#(
    parameter int unsigned N_ENT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_req,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic [1:0]       lk_acc,
    input  logic             lk_sup,
    input  logic             fl_req,
    input  logic             rf_req,
    input  logic [VPN_W-1:0] rf_vpn,
    input  logic [PPN_W-1:0] rf_ppn,
    input  logic [3:0]       rf_perm,
    input  logic             rf_sup,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic             rsp_fault,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rf_reject
);
    localparam int unsigned IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

    typedef struct packed {
        entry_t [N_ENT-1:0] ent;
        logic [IDX_W-1:0]   rr;
        logic               rsp_valid;
        logic               rsp_hit;
        logic               rsp_miss;
        logic               rsp_fault;
        logic [PA_W-1:0]    rsp_paddr;
        logic               rf_reject;
    } state_t;

    state_t s_d, s_q;

    logic             lk_any, rf_any, lk_allow, rr_adv;
    logic [IDX_W-1:0] lk_idx, rf_idx, rr_nx, wr_idx;
    entry_t           lk_ent;
    logic             rf_ok;

    tlb_prot_cam #(.N_ENT(N_ENT)) lk_cam_i (
        .ents (s_q.ent),
        .vpn  (lk_vaddr[VA_W-1:OFF_W]),
        .any  (lk_any),
        .idx  (lk_idx)
    );

    tlb_prot_cam #(.N_ENT(N_ENT)) rf_cam_i (
        .ents (s_q.ent),
        .vpn  (rf_vpn),
        .any  (rf_any),
        .idx  (rf_idx)
    );

    assign lk_ent = s_q.ent[lk_idx];

    tlb_prot_perm perm_i (
        .perm  (lk_ent.perm),
        .acc   (acc_e'(lk_acc)),
        .sup   (lk_sup),
        .allow (lk_allow)
    );

    assign rf_ok  = rf_req && rf_sup && !fl_req;
    assign rr_adv = rf_ok && !rf_any;
    assign wr_idx = rf_any ? rf_idx : s_q.rr;

    tlb_prot_rr #(.N_ENT(N_ENT)) rr_i (
        .ptr    (s_q.rr),
        .adv    (rr_adv),
        .ptr_nx (rr_nx)
    );

    always_comb begin
        s_d = s_q;

        // lookup result, computed against the table before this cycle's updates
        s_d.rsp_valid = lk_req;
        s_d.rsp_hit   = 1'b0;
        s_d.rsp_miss  = 1'b0;
        s_d.rsp_fault = 1'b0;
        s_d.rsp_paddr = '0;
        if (lk_req) begin
            if (fl_req || !lk_any) begin
                s_d.rsp_miss = 1'b1;
            end else if (lk_allow) begin
                s_d.rsp_hit   = 1'b1;
                s_d.rsp_paddr = {lk_ent.ppn, lk_vaddr[OFF_W-1:0]};
            end else begin
                s_d.rsp_fault = 1'b1;
            end
        end

        s_d.rf_reject = rf_req && !rf_sup;

        // table update: flush dominates refill
        if (fl_req) begin
            for (int i = 0; i < N_ENT; i++) s_d.ent[i].valid = 1'b0;
        end else if (rf_ok) begin
            s_d.ent[wr_idx] = '{valid: 1'b1, vpn: rf_vpn, ppn: rf_ppn,
                                perm: perm_t'(rf_perm)};
        end
        s_d.rr = rr_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rsp_valid = s_q.rsp_valid;
    assign rsp_hit   = s_q.rsp_hit;
    assign rsp_miss  = s_q.rsp_miss;
    assign rsp_fault = s_q.rsp_fault;
    assign rsp_paddr = s_q.rsp_paddr;
    assign rf_reject = s_q.rf_reject;
endmodule

// File: rtl/tlb_prot_chk.sv
module tlb_prot_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        lk_req,
    input logic [11:0] lk_off,
    input logic        fl_req,
    input logic        rf_req,
    input logic        rf_sup,
    input logic        rsp_valid,
    input logic        rsp_hit,
    input logic        rsp_miss,
    input logic        rsp_fault,
    input logic [11:0] rsp_off,
    input logic        rf_reject
);
    // R2
    valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid);

    // R2
    idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !rsp_valid);

    // R2
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1);

    // R2
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault));

    // R4
    offset_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && !fl_req) |=> (rsp_hit |-> rsp_off == $past(lk_off)));

    // R7
    reject_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_req && !rf_sup) |=> rf_reject);

    // R7
    no_spurious_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_req && !rf_sup) |=> !rf_reject);

    // R10
    flush_lookup_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && lk_req) |=> rsp_miss);
endmodule

bind tlb_prot tlb_prot_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_req    (lk_req),
    .lk_off    (lk_vaddr[11:0]),
    .fl_req    (fl_req),
    .rf_req    (rf_req),
    .rf_sup    (rf_sup),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_miss  (rsp_miss),
    .rsp_fault (rsp_fault),
    .rsp_off   (rsp_paddr[11:0]),
    .rf_reject (rf_reject)
);

// File: tb/tlb_prot_tb.sv
module tlb_prot_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic [23:0] lk_vaddr = '0;
    logic [1:0]  lk_acc = '0;
    logic        lk_sup = 1'b0;
    logic        fl_req = 1'b0;
    logic        rf_req = 1'b0;
    logic [11:0] rf_vpn = '0;
    logic [11:0] rf_ppn = '0;
    logic [3:0]  rf_perm = '0;
    logic        rf_sup = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault, rf_reject;
    logic [23:0] rsp_paddr;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlb_prot #(.N_ENT(N)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .lk_req(lk_req), .lk_vaddr(lk_vaddr), .lk_acc(lk_acc), .lk_sup(lk_sup),
        .fl_req(fl_req),
        .rf_req(rf_req), .rf_vpn(rf_vpn), .rf_ppn(rf_ppn), .rf_perm(rf_perm),
        .rf_sup(rf_sup),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr), .rf_reject(rf_reject)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one cycle with any mix of flush, lookup, refill; results readable on return
    task automatic cyc(input logic fl, input logic lk, input logic [23:0] va,
                       input logic [1:0] acc, input logic sup,
                       input logic rf, input logic [11:0] vpn, input logic [11:0] ppn,
                       input logic [3:0] perm, input logic rsup);
        @(negedge clk);
        fl_req = fl; lk_req = lk; lk_vaddr = va; lk_acc = acc; lk_sup = sup;
        rf_req = rf; rf_vpn = vpn; rf_ppn = ppn; rf_perm = perm; rf_sup = rsup;
        @(posedge clk);
        @(negedge clk);
        fl_req = 0; lk_req = 0; rf_req = 0;
    endtask

    task automatic look(input logic [23:0] va, input logic [1:0] acc, input logic sup);
        cyc(0, 1, va, acc, sup, 0, 0, 0, 0, 0);
    endtask

    task automatic fill(input logic [11:0] vpn, input logic [11:0] ppn, input logic [3:0] perm);
        cyc(0, 0, 0, 0, 0, 1, vpn, ppn, perm, 1);
    endtask

    // {hit,miss,fault}
    function automatic logic [2:0] res();
        return {rsp_hit, rsp_miss, rsp_fault};
    endfunction

    task automatic t_reset();
        chk("R1 valid after reset", rsp_valid, 0);
        chk("R1 reject after reset", rf_reject, 0);
        look(24'h123456, 0, 1);
        chk("R1 first lookup misses", res(), 3'b010);
        chk("R2 valid one cycle later", rsp_valid, 1);
        @(negedge clk);
        chk("R2 valid drops when idle", rsp_valid, 0);
    endtask

    task automatic t_hit();
        fill(12'h123, 12'hABC, 4'b1111);
        look(24'h123456, 0, 0);
        chk("R4 hit", res(), 3'b100);
        chk("R4 paddr", rsp_paddr, 24'hABC456);
        look(24'h124000, 0, 0);
        chk("R3 miss", res(), 3'b010);
        chk("R3 paddr zero on miss", rsp_paddr, 0);
    endtask

    task automatic t_perm();
        fill(12'h200, 12'h055, 4'b1001);
        look(24'h200010, 0, 0);
        chk("R5 read allowed", res(), 3'b100);
        look(24'h200010, 1, 0);
        chk("R5 write forbidden", res(), 3'b001);
        look(24'h200010, 2, 1);
        chk("R5 exec forbidden", res(), 3'b001);
        look(24'h200010, 3, 1);
        chk("R5 kind 3 forbidden", res(), 3'b001);
        fill(12'h201, 12'h066, 4'b0111);
        look(24'h201abc, 1, 0);
        chk("R6 user on supervisor page", res(), 3'b001);
        look(24'h201abc, 1, 1);
        chk("R6 supervisor ignores user flag", res(), 3'b100);
        chk("R6 paddr", rsp_paddr, 24'h066abc);
    endtask

    task automatic t_reject();
        cyc(0, 0, 0, 0, 0, 1, 12'h300, 12'h077, 4'b1111, 0);
        chk("R7 reject flagged", rf_reject, 1);
        look(24'h300000, 0, 1);
        chk("R7 refused refill not installed", res(), 3'b010);
        chk("R7 reject is one cycle", rf_reject, 0);
        cyc(0, 0, 0, 0, 0, 1, 12'h123, 12'h999, 4'b1111, 0);
        look(24'h123000, 0, 1);
        chk("R7 refused refill keeps old mapping", rsp_paddr, 24'hABC000);
    endtask

    task automatic t_flush();
        cyc(1, 1, 24'h123456, 0, 1, 0, 0, 0, 0, 0);
        chk("R10 lookup during flush misses", res(), 3'b010);
        look(24'h123456, 0, 1);
        chk("R10 entry gone", res(), 3'b010);
        look(24'h200000, 0, 1);
        chk("R10 second entry gone", res(), 3'b010);
    endtask

    task automatic t_rr();
        for (int i = 0; i < N; i++) fill(12'h400 + 12'(i), 12'h800 + 12'(i), 4'b1111);
        fill(12'h403, 12'hF03, 4'b1111);
        for (int i = 0; i < N; i++) begin
            look({12'h400 + 12'(i), 12'h00C}, 0, 0);
            chk("R8 all pages still cached", res(), 3'b100);
        end
        look(24'h40300C, 0, 0);
        chk("R8 overwritten in place", rsp_paddr, 24'hF0300C);
        fill(12'h408, 12'h808, 4'b1111);
        fill(12'h409, 12'h809, 4'b1111);
        look(24'h400000, 0, 0);
        chk("R9 oldest evicted", res(), 3'b010);
        look(24'h401000, 0, 0);
        chk("R9 second oldest evicted", res(), 3'b010);
        look(24'h402000, 0, 0);
        chk("R9 third kept", res(), 3'b100);
        look(24'h408111, 0, 0);
        chk("R9 new page", rsp_paddr, 24'h808111);
        look(24'h409222, 0, 0);
        chk("R9 newest page", rsp_paddr, 24'h809222);
    endtask

    task automatic t_same_cycle();
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        cyc(0, 1, 24'h500123, 0, 1, 1, 12'h500, 12'h0AA, 4'b1111, 1);
        chk("R11 lookup sees old table", res(), 3'b010);
        look(24'h500123, 0, 1);
        chk("R11 refill then visible", rsp_paddr, 24'h0AA123);
        cyc(1, 1, 24'h500123, 0, 1, 1, 12'h600, 12'h0BB, 4'b1111, 1);
        chk("R10 flush beats hit", res(), 3'b010);
        look(24'h600000, 0, 1);
        chk("R12 refill dropped by flush", res(), 3'b010);
        look(24'h500000, 0, 1);
        chk("R12 flush applied", res(), 3'b010);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_hit();
        t_perm();
        t_reject();
        t_flush();
        t_rr();
        t_same_cycle();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule